// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a synchronous host reach an external static RAM module that has no clock. The RAM is 32 bits wide and built from four byte lanes. Each lane has its own active-low chip select and write strobe. One active-low read strobe is shared by all lanes. The controller accepts one request at a time on a valid/ready port. It places the row address on the RAM pins, walks the strobes through a fixed phase sequence, and returns a one-cycle acknowledge. For reads the acknowledge carries the data word.

Every phase lasts a whole number of clock cycles. These counts are derived at elaboration time by rounding each nanosecond limit of the RAM up to whole clock periods. The limits covered are access time, read-strobe-to-data time, write pulse width, address-to-write-end time, data-to-write-end time and cycle time. A plain configuration input selects how the 32-bit array is seen by the host: as one 32-bit word per row, as two 16-bit halves, or as four bytes. In the narrow views the low host address bits pick the lanes that are strobed.

The request port applies back-pressure only through `req_ready`. It is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the payload must be held stable while `req_valid` is high. The response port has no ready signal: the host must take `rsp_valid` in the single cycle it is high. `cfg_org` is captured together with each request.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and in the first idle cycle after it, all chip selects, all write strobes and the read strobe are high, the data drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the controller is idle again.
- R3: The controller drives the data bus only while the read strobe is high. Whenever any write strobe is low, the read strobe is high and that lane's chip select is low.
- R4: For a read, the row address stays stable while any chip select is low. The read strobe stays low for at least ceil(t_oe/T) cycles. Data is sampled only after the chip select has been low for ceil(t_aa/T) cycles.
- R5: For a write, the write strobe of each enabled lane stays low for at least ceil(max(t_wp, t_aw-T, t_dw-T)/T) cycles. Data is driven from the setup cycle through the cycle after the strobe rises.
- R6: `rsp_valid` is high for exactly one cycle, in the cycle after the last strobe cycle. For a read, `rsp_rdata` holds the sampled word in that cycle.
- R7: With `cfg_org` = 2'b00 or 2'b11 (32-bit view), the RAM row is `req_addr[18:0]` and bits 20..19 are ignored. `req_mask[i]` enables byte lane i (data bits 8i+7..8i) for writes, and reads return the full row.
- R8: With `cfg_org` = 2'b01 (16-bit view), the row is `req_addr[19:1]`. `req_addr[0]` = 0 selects lanes 1..0 and 1 selects lanes 3..2. Write data is taken from bits 15..0, `req_mask[1:0]` enables the low and high byte of the half, and reads return the half zero-extended.
- R9: With `cfg_org` = 2'b10 (8-bit view), the row is `req_addr[20:2]` and `req_addr[1:0]` selects a single lane. Write data is taken from bits 7..0, `req_mask[0]` enables the write, and reads return the byte zero-extended. At most one chip select is ever low in this view.
- R10: A write leaves every byte lane whose mask bit is clear unchanged in the RAM. A write with an all-clear mask changes nothing.
- R11: The first chip select falls one cycle after acceptance when the request has the same direction as the previous one, and two cycles after when the direction changes. The direction before the first request after reset counts as read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_org | input | 2 | Array view: 00/11 32-bit, 01 16-bit, 10 8-bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+2 | Host address in units of the selected view |
| req_wdata | input | 4*LANE_W | Write data, right-aligned for narrow views |
| req_mask | input | 4 | Byte-lane write enables, right-aligned for narrow views |
| rsp_valid | output | 1 | One-cycle acknowledge |
| rsp_rdata | output | 4*LANE_W | Read data, right-aligned and zero-extended |
| mem_addr | output | ROW_W | RAM row address |
| mem_ce_n | output | 4 | Per-lane active-low chip select |
| mem_we_n | output | 4 | Per-lane active-low write strobe |
| mem_oe_n | output | 1 | Shared active-low read strobe |
| mem_dq_o | output | 4*LANE_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_i | input | 4*LANE_W | Data from the RAM pins |

## Verification
On every cycle the assertions check the strobe relationships:
- no data drive while the read strobe is low;
- no write strobe without its chip select;
- a stable address under an active select;
- minimum low times of the write and read strobes, counted in the controller;
- the single-cycle acknowledge;
- one-lane and one-half selection in the narrow views;
- the turnaround cycle on a change of direction.

Only the bench's scenarios can show that data lands in the right lane and row. This is done by writing through one view and reading back through another, with partial and empty masks and the highest row. A behavioural RAM returns garbage if data is sampled before its access time, and it flags bus contention and short write pulses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ORG_X32 = 2'b00,
    ORG_X16 = 2'b01,
    ORG_X8  = 2'b10,
    ORG_ALT = 2'b11
  } org_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_TURN    = 3'd1,
    PH_SETUP   = 3'd2,
    PH_ACCESS  = 3'd3,
    PH_RECOVER = 3'd4
  } phase_e;

  function automatic int cycles_for(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_ctrl_pkg::*;
#(
  parameter  int ROW_W  = 19,
  parameter  int LANE_W = 8,
  localparam int LANES  = 4,
  localparam int DW     = LANES * LANE_W,
  localparam int HA_W   = ROW_W + 2
) (
  input  org_e              org,
  input  logic [HA_W-1:0]   haddr,
  input  logic [DW-1:0]     hwdata,
  input  logic [LANES-1:0]  hmask,
  output logic [ROW_W-1:0]  row,
  output logic [LANES-1:0]  rd_lanes,
  output logic [LANES-1:0]  wr_lanes,
  output logic [DW-1:0]     lane_wdata
);

  localparam logic [LANES-1:0] LOW_PAIR  = LANES'(4'b0011);
  localparam logic [LANES-1:0] HIGH_PAIR = LANES'(4'b1100);

  always_comb begin
    unique case (org)
      ORG_X16: begin
        row        = haddr[ROW_W:1];
        rd_lanes   = haddr[0] ? HIGH_PAIR : LOW_PAIR;
        wr_lanes   = haddr[0] ? {hmask[1:0], 2'b00} : {2'b00, hmask[1:0]};
        lane_wdata = {2{hwdata[2*LANE_W-1:0]}};
      end
      ORG_X8: begin
        row        = haddr[ROW_W+1:2];
        rd_lanes   = LANES'(1) << haddr[1:0];
        wr_lanes   = LANES'(hmask[0]) << haddr[1:0];
        lane_wdata = {LANES{hwdata[LANE_W-1:0]}};
      end
      default: begin
        row        = haddr[ROW_W-1:0];
        rd_lanes   = '1;
        wr_lanes   = hmask;
        lane_wdata = hwdata;
      end
    endcase
  end

endmodule

// File: rtl/sram_read_align.sv
module sram_read_align
  import sram_ctrl_pkg::*;
#(
  parameter  int LANE_W = 8,
  localparam int LANES  = 4,
  localparam int DW     = LANES * LANE_W
) (
  input  org_e          org,
  input  logic [1:0]    sub,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] word
);

  logic [2*LANE_W-1:0] half_sel;
  logic [LANE_W-1:0]   byte_sel;

  always_comb begin
    half_sel = sub[0] ? raw[DW-1:2*LANE_W] : raw[2*LANE_W-1:0];
    byte_sel = raw[sub*LANE_W +: LANE_W];
    unique case (org)
      ORG_X16: word = DW'(half_sel);
      ORG_X8:  word = DW'(byte_sel);
      default: word = raw;
    endcase
  end

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter  int RD_CYC  = 2,
  parameter  int WR_CYC  = 2,
  parameter  int REC_CYC = 1,
  localparam int MAX_CYC = max3(RD_CYC, WR_CYC, REC_CYC),
  localparam int CNT_W   = $clog2(MAX_CYC + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_write,
  output phase_e phase,
  output logic   cur_write,
  output logic   last_access,
  output logic   ready
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prev_write_q;

  assign phase       = phase_q;
  assign ready       = (phase_q == PH_IDLE);
  assign last_access = (phase_q == PH_ACCESS) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_IDLE;
      cnt_q        <= '0;
      cur_write    <= 1'b0;
      prev_write_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start) begin
          cur_write    <= start_write;
          prev_write_q <= start_write;
          phase_q      <= (start_write != prev_write_q) ? PH_TURN : PH_SETUP;
        end
        PH_TURN: phase_q <= PH_SETUP;
        PH_SETUP: begin
          phase_q <= PH_ACCESS;
          cnt_q   <= cur_write ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
        PH_ACCESS: begin
          if (cnt_q == '0) begin
            phase_q <= PH_RECOVER;
            cnt_q   <= CNT_W'(REC_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_RECOVER: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R11: a change of direction passes through the turnaround phase
  assert_dir_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (start_write != prev_write_q)) |=> (phase_q == PH_TURN));

  // R11: the same direction goes straight to setup
  assert_same_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (start_write == prev_write_q)) |=> (phase_q == PH_SETUP));

  // R2: once taken, the request holds the controller busy
  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter  int ROW_W   = 19,
  parameter  int LANE_W  = 8,
  parameter  int CLK_NS  = 10,
  parameter  int T_RC_NS = 20,
  parameter  int T_AA_NS = 20,
  parameter  int T_OE_NS = 10,
  parameter  int T_WC_NS = 20,
  parameter  int T_WP_NS = 13,
  parameter  int T_AW_NS = 13,
  parameter  int T_DW_NS = 9,
  localparam int LANES   = 4,
  localparam int DW      = LANES * LANE_W,
  localparam int HA_W    = ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_org,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [HA_W-1:0]   req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [LANES-1:0]  mem_ce_n,
  output logic [LANES-1:0]  mem_we_n,
  output logic              mem_oe_n,
  output logic [DW-1:0]     mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_i
);

  // Phase lengths: setup contributes one period before the strobe phase.
  localparam int RD_RAW  = max3(cycles_for(T_OE_NS, CLK_NS),
                                cycles_for(T_AA_NS, CLK_NS) - 1,
                                cycles_for(T_RC_NS, CLK_NS) - 2);
  localparam int WR_RAW  = max3(cycles_for(T_WP_NS, CLK_NS),
                                max3(cycles_for(T_AW_NS, CLK_NS) - 1,
                                     cycles_for(T_DW_NS, CLK_NS) - 1, 0),
                                cycles_for(T_WC_NS, CLK_NS) - 2);
  localparam int RD_CYC  = (RD_RAW < 1) ? 1 : RD_RAW;
  localparam int WR_CYC  = (WR_RAW < 1) ? 1 : WR_RAW;
  localparam int REC_CYC = 1;
  localparam int RUN_W   = $clog2(max3(RD_CYC, WR_CYC, 1) + 2);

  org_e             org_q;
  logic [HA_W-1:0]  addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    rdata_q;
  logic             rsp_q;

  phase_e phase;
  logic   cur_write, last_access, start;

  logic [ROW_W-1:0] row;
  logic [LANES-1:0] rd_lanes, wr_lanes;
  logic [DW-1:0]    lane_wdata, aligned;

  assign start = req_valid && req_ready;

  sram_phase_fsm #(
    .RD_CYC (RD_CYC),
    .WR_CYC (WR_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_write(req_write),
    .phase      (phase),
    .cur_write  (cur_write),
    .last_access(last_access),
    .ready      (req_ready)
  );

  sram_lane_map #(.ROW_W(ROW_W), .LANE_W(LANE_W)) u_map (
    .org       (org_q),
    .haddr     (addr_q),
    .hwdata    (wdata_q),
    .hmask     (mask_q),
    .row       (row),
    .rd_lanes  (rd_lanes),
    .wr_lanes  (wr_lanes),
    .lane_wdata(lane_wdata)
  );

  sram_read_align #(.LANE_W(LANE_W)) u_align (
    .org (org_q),
    .sub (addr_q[1:0]),
    .raw (mem_dq_i),
    .word(aligned)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      org_q   <= ORG_X32;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (start) begin
        org_q   <= org_e'(cfg_org);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_mask;
      end
      if (last_access && !cur_write) rdata_q <= aligned;
      rsp_q <= last_access;
    end
  end

  logic bus_active, strobe_phase;
  assign bus_active   = (phase == PH_SETUP) || (phase == PH_ACCESS) || (phase == PH_RECOVER);
  assign strobe_phase = (phase == PH_ACCESS);

  assign mem_addr  = row;
  assign mem_ce_n  = ~(bus_active ? (cur_write ? wr_lanes : rd_lanes) : '0);
  assign mem_we_n  = ~((strobe_phase && cur_write) ? wr_lanes : '0);
  assign mem_oe_n  = !(strobe_phase && !cur_write);
  assign mem_dq_o  = lane_wdata;
  assign mem_dq_oe = bus_active && cur_write;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // ---------------- checks next to the pin logic ----------------
  logic             we_low, oe_low, ce_any;
  logic [RUN_W-1:0] we_run, oe_run;
  assign we_low = (mem_we_n != '1);
  assign oe_low = !mem_oe_n;
  assign ce_any = (mem_ce_n != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= we_low ? ((we_run == '1) ? we_run : we_run + 1'b1) : '0;
      oe_run <= oe_low ? ((oe_run == '1) ? oe_run : oe_run + 1'b1) : '0;
    end
  end

  assert_no_drive_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_we_excludes_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_low |-> (mem_oe_n && mem_dq_oe));

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mem_we_n & mem_ce_n) == '0));

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_any && $past(ce_any)) |-> $stable(mem_addr));

  assert_oe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_low) |-> (oe_run >= RUN_W'(RD_CYC)));

  assert_we_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_low) |-> (we_run >= RUN_W'(WR_CYC)));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_low) |-> mem_dq_oe);

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_x16_one_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (org_q == ORG_X16) |->
      (((~mem_ce_n) & LANES'(4'b0011)) == '0 || ((~mem_ce_n) & LANES'(4'b1100)) == '0));

  assert_x8_one_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (org_q == ORG_X8) |-> ($countones(~mem_ce_n) <= 1));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!ce_any && !we_low && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

  localparam int CLK_NS  = 8;
  localparam int AA_NEED = (20 + CLK_NS - 1) / CLK_NS;
  localparam int OE_NEED = (10 + CLK_NS - 1) / CLK_NS;
  localparam int WP_NEED = (13 + CLK_NS - 1) / CLK_NS;
  localparam int ACC_RD  = (OE_NEED > AA_NEED - 1) ? OE_NEED : AA_NEED - 1;
  localparam int ACC_WR  = WP_NEED;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_org = 2'b00;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic [3:0]  mem_ce_n, mem_we_n;
  logic        mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o, mem_dq_i;

  always #4 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_org(cfg_org),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  // ---------------- behavioural RAM ----------------
  logic [7:0]  ram [int unsigned];
  logic [31:0] model_q = 32'hEEEE_EEEE;
  int          ce_cnt [4];
  int          oe_cnt [4];
  int          we_cnt [4];
  int          viol = 0;
  logic [18:0] last_row = '0;
  assign mem_dq_i = model_q;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < 4; l++) begin
        automatic bit ce = !mem_ce_n[l];
        automatic bit we = !mem_we_n[l];
        automatic bit rd = ce && !we && !mem_oe_n;
        automatic int unsigned key = {mem_addr, 2'(l)};
        ce_cnt[l] = (ce && mem_addr == last_row) ? ce_cnt[l] + 1 : (ce ? 1 : 0);
        oe_cnt[l] = rd ? oe_cnt[l] + 1 : 0;
        if (we) begin
          if (!mem_dq_oe) viol++;
          else ram[key] = mem_dq_o[l*8 +: 8];
          we_cnt[l]++;
        end else begin
          if (we_cnt[l] != 0 && we_cnt[l] < WP_NEED) viol++;
          we_cnt[l] = 0;
        end
        if (rd && mem_dq_oe) viol++;
        if (rd && ce_cnt[l] >= AA_NEED && oe_cnt[l] >= OE_NEED)
          model_q[l*8 +: 8] = ram.exists(key) ? ram[key] : 8'h00;
        else
          model_q[l*8 +: 8] = 8'hEE;
      end
      last_row = mem_addr;
    end
  end

  // ---------------- bookkeeping ----------------
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // ---------------- vector table ----------------
  typedef struct packed {
    logic [1:0]  org;
    logic        wr;
    logic [20:0] addr;
    logic [31:0] wd;
    logic [3:0]  mask;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 20;
  localparam logic [91:0] VECS [NV] = '{
    {2'd0, 1'b1, 21'h000010, 32'hA1B2C3D4, 4'hF, 32'h0},        // R7 write
    {2'd0, 1'b0, 21'h000010, 32'h0,        4'hF, 32'hA1B2C3D4}, // R7 read
    {2'd0, 1'b1, 21'h000010, 32'h11223344, 4'h5, 32'h0},        // R10 lanes 0,2
    {2'd0, 1'b0, 21'h000010, 32'h0,        4'hF, 32'hA122C344}, // R10
    {2'd1, 1'b1, 21'h000021, 32'h0000BEEF, 4'h3, 32'h0},        // R8 high half
    {2'd1, 1'b0, 21'h000021, 32'h0,        4'hF, 32'h0000BEEF}, // R8
    {2'd1, 1'b0, 21'h000020, 32'h0,        4'hF, 32'h0000C344}, // R8 low half
    {2'd2, 1'b1, 21'h000041, 32'h0000005A, 4'h1, 32'h0},        // R9 byte 1
    {2'd0, 1'b0, 21'h000010, 32'h0,        4'hF, 32'hBEEF5A44}, // R9 via x32
    {2'd2, 1'b0, 21'h000043, 32'h0,        4'hF, 32'h000000BE}, // R9 byte 3
    {2'd2, 1'b1, 21'h000040, 32'h00000077, 4'h0, 32'h0},        // R10 empty mask
    {2'd2, 1'b0, 21'h000040, 32'h0,        4'hF, 32'h00000044}, // R10
    {2'd0, 1'b1, 21'h07FFFF, 32'hDEADBEEF, 4'hF, 32'h0},        // R7 top row
    {2'd1, 1'b0, 21'h0FFFFE, 32'h0,        4'hF, 32'h0000BEEF}, // R8 top row
    {2'd2, 1'b0, 21'h1FFFFF, 32'h0,        4'hF, 32'h000000DE}, // R9 top row
    {2'd3, 1'b1, 21'h000155, 32'hCAFEF00D, 4'hF, 32'h0},        // R7 code 11
    {2'd3, 1'b1, 21'h000156, 32'h01020304, 4'hF, 32'h0},        // R11 write after write
    {2'd0, 1'b0, 21'h000155, 32'h0,        4'hF, 32'hCAFEF00D}, // R7
    {2'd0, 1'b0, 21'h000156, 32'h0,        4'hF, 32'h01020304}, // R7
    {2'd0, 1'b0, 21'h180155, 32'h0,        4'hF, 32'hCAFEF00D}  // R7 upper bits ignored
  };

  bit prev_wr = 1'b0;

  task automatic run_vec(input vec_t v, input int idx);
    int n, lat, rsp_n, exp_lat, exp_rsp;
    logic [31:0] rd;
    lat = 0; rsp_n = 0; rd = '0;
    @(negedge clk);
    cfg_org = v.org; req_write = v.wr; req_addr = v.addr;
    req_wdata = v.wd; req_mask = v.mask; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, $sformatf("R2 vec%0d ready while busy", idx), 32'(req_ready), 32'h0);
    n = 1;
    while (n < 40) begin
      if (lat == 0 && mem_ce_n != 4'hF) lat = n;
      if (rsp_valid) begin rsp_n = n; rd = rsp_rdata; break; end
      @(negedge clk);
      n++;
    end
    exp_lat = (v.wr != prev_wr) ? 2 : 1;
    exp_rsp = exp_lat + (v.wr ? ACC_WR : ACC_RD) + 1;
    prev_wr = v.wr;
    if (v.mask != 4'h0 || !v.wr)
      chk(lat == exp_lat, $sformatf("R11 vec%0d select latency", idx), 32'(lat), 32'(exp_lat));
    chk(rsp_n == exp_rsp, $sformatf("R6 vec%0d ack cycle", idx), 32'(rsp_n), 32'(exp_rsp));
    if (!v.wr)
      chk(rd == v.exp, $sformatf("R7/R8/R9/R10 vec%0d read data", idx), rd, v.exp);
    @(negedge clk);
    chk(rsp_valid == 1'b0, $sformatf("R6 vec%0d ack one cycle", idx), 32'(rsp_valid), 32'h0);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin ce_cnt[l] = 0; oe_cnt[l] = 0; we_cnt[l] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held quiet during reset
    chk(mem_ce_n == 4'hF && mem_we_n == 4'hF && mem_oe_n && !mem_dq_oe,
        "R1 strobes in reset", {mem_ce_n, mem_we_n, 3'b0, mem_oe_n, 3'b0, mem_dq_oe, 16'h0},
        32'hFF10_0000);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 no ack after reset", 32'(rsp_valid), 32'h0);
    chk(mem_ce_n == 4'hF && mem_we_n == 4'hF, "R1 selects idle",
        {24'h0, mem_ce_n, mem_we_n}, 32'h0000_00FF);
    chk(mem_oe_n == 1'b1 && mem_dq_oe == 1'b0, "R1 read strobe and drive idle",
        {30'h0, mem_oe_n, mem_dq_oe}, 32'h2);

    for (int i = 0; i < NV; i++) run_vec(vec_t'(VECS[i]), i);

    // R3 R4 R5: the RAM model saw no contention, short strobe or undriven write
    chk(viol == 0, "R3/R4/R5 bus protocol violations", 32'(viol), 32'h0);

    // R2: with valid low the controller stays idle
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && mem_ce_n == 4'hF, "R2 stays idle without request",
        {27'h0, req_ready, mem_ce_n}, 32'h1F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule